// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM that never needs an idle cycle between a read and a write. Each word is 18 bits wide and is split into two 9-bit byte lanes. Every enabled clock edge is decoded as one of these cycles:

- a deselect,
- the start of a read or write burst at an external address,
- a continuation of the running burst,
- a dummy read (output enable high),
- an abort write (both lane enables high),
- an ignored edge.

A 2-bit counter steps through a burst of four words in linear order on the low two address bits. After the fourth word it wraps to the starting word.

Write data and lane enables travel one enabled edge behind the write command. This lets a read and a write alternate on every edge with no idle cycle. Read data is flow-through: in the cycle that follows the edge that registers a read, the data bus shows the word at the address latched at that edge. The bidirectional data pins are modelled as separate input data, output data and an output-drive flag.

Top module: `zbt_sram`

## Requirements
- R1: The chip counts as selected only when `sel_a_n` and `sel_b_n` are both 0 and `sel_c` is 1. A begin cycle (`adv_ld`=0) with any other combination is a deselect: it drives no data, writes nothing and ends any running burst.
- R2: A selected begin cycle uses `addr`, and `rw_n`=1 means read. In the cycle after that edge, `dout` shows the stored word at `addr` and `dout_en` is 1, provided `oe_n` is 0.
- R3: A continue cycle (`adv_ld`=1) repeats the read or write type latched at the most recent selected begin cycle. During a continue cycle, `rw_n` and the select pins have no effect. A continue cycle that follows a deselect is itself a deselect.
- R4: Each continue cycle of a live burst moves to the next address. The upper address bits are kept and the low two bits are (start + n) mod 4, where n counts the continue cycles since the begin. The fifth word of a burst is therefore the starting word again.
- R5: The data for a write command is taken from `din` at the next enabled edge. The lane enables are sampled at that same edge, where `bwa_n`=0 writes bits [8:0] and `bwb_n`=0 writes bits [17:9].
- R6: A write whose delayed lane enables are both 1 is an abort write. It leaves memory unchanged, but it still starts or advances the burst.
- R7: A read with `oe_n`=1 is a dummy read. `dout_en` stays 0 for that cycle, but the burst still starts or advances.
- R8: An edge with `cke_n`=1 changes no state, and any pending write waits for the next enabled edge. `dout`/`dout_en` keep showing read data if the last registered cycle was a read, and stay off otherwise.
- R9: `dout_en` is 0 after reset and during every write or deselect cycle, whatever the level of `oe_n`.
- R10: While `snooze` is 1, address, control and data inputs are ignored and no state changes. `dout_en` is 0 during snooze. After snooze ends, a burst resumes exactly as if the snooze cycles had not occurred.
- R11: A read registered on the edge that completes a write to the same address returns the newly written, lane-merged word. No idle cycle is needed in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW (8) | Word address for begin cycles |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| rw_n | input | 1 | 1 = read, 0 = write, sampled on begin cycles |
| adv_ld | input | 1 | 0 = begin at `addr`, 1 = continue burst |
| cke_n | input | 1 | 1 = ignore this clock edge |
| bwa_n | input | 1 | Low lane (bits 8:0) write enable, active low, one edge after the command |
| bwb_n | input | 1 | High lane (bits 17:9) write enable, active low, one edge after the command |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| snooze | input | 1 | Freeze input; ignores all other inputs while high |
| din | input | 18 | Write data, one edge after the command |
| dout | output | 18 | Read data (flow-through) |
| dout_en | output | 1 | 1 when the block drives the data bus |

## Verification
A wrong burst counter or start latch shows up within one cycle as the wrong word on `dout`. It becomes most visible on the fourth continue, where the wrap must land on the start word. A broken write pipeline has two failure modes: data lands at a neighbouring address, or data lands one edge early or late. Either one appears at the port on the first read of that address, and in the interleaved pattern that read is on the very next edge. A lost inherited read/write type, or a wrongly kept burst after a deselect, turns `dout_en` on or off in the cycle after the faulty edge.

// File: rtl/zbt_pkg.sv
// Package zbt_pkg
// Shared cycle type and lane geometry for the burst SRAM model.
// Assumes two byte lanes of nine bits each.
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
endpackage

// File: rtl/zbt_ctrl.sv
// Module zbt_ctrl
// Decodes each enabled edge into deselect / begin / continue cycles,
// keeps the 2-bit linear burst counter and the one-deep write pipeline.
// Assumes AW >= 3; step is low on ignored or snoozed edges.
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          sel,
    input  logic          rw_n,
    input  logic          adv_ld,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] cur_addr_q,
    output logic          wr_pend_q,
    output logic [AW-1:0] wr_addr_q
);
    localparam int HI_W = AW - 2;

    logic          live_q;
    logic          burst_wr_q;
    logic [1:0]    cnt_q;
    logic [1:0]    start_lo_q;
    logic [1:0]    nxt_lo;
    logic [AW-1:0] burst_addr;

    // Next linear burst address: upper bits fixed, low bits wrap mod 4.
    always_comb begin
        nxt_lo     = start_lo_q + cnt_q + 2'd1;
        burst_addr = {cur_addr_q[AW-1:2], nxt_lo};
    end

    // Cycle decode, burst state and write pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_IDLE;
            live_q     <= 1'b0;
            burst_wr_q <= 1'b0;
            cnt_q      <= 2'd0;
            start_lo_q <= 2'd0;
            cur_addr_q <= '0;
            wr_pend_q  <= 1'b0;
            wr_addr_q  <= '0;
        end else if (step) begin
            wr_pend_q <= 1'b0;
            if (!adv_ld) begin
                if (sel) begin
                    live_q     <= 1'b1;
                    burst_wr_q <= !rw_n;
                    cnt_q      <= 2'd0;
                    start_lo_q <= addr[1:0];
                    cur_addr_q <= addr;
                    op_q       <= rw_n ? OP_READ : OP_WRITE;
                    wr_pend_q  <= !rw_n;
                    wr_addr_q  <= addr;
                end else begin
                    live_q <= 1'b0;
                    op_q   <= OP_IDLE;
                end
            end else if (live_q) begin
                cnt_q      <= cnt_q + 2'd1;
                cur_addr_q <= burst_addr;
                op_q       <= burst_wr_q ? OP_WRITE : OP_READ;
                wr_pend_q  <= burst_wr_q;
                wr_addr_q  <= burst_addr;
            end else begin
                op_q <= OP_IDLE;
            end
        end
    end

    // R4: a continue on a live burst steps the counter by one, upper bits kept
    a_r4_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && adv_ld && live_q) |=>
            (cnt_q == 2'($past(cnt_q) + 2'd1)) &&
            (cur_addr_q[AW-1:2] == $past(cur_addr_q[AW-1:2])));

    // R3: a continue with no live burst yields an idle cycle
    a_r3_cont_after_dsel: assert property (@(posedge clk) disable iff (!rst_n)
        (step && adv_ld && !live_q) |=> (op_q == OP_IDLE) && !wr_pend_q);

    // R1: an unselected begin ends the burst
    a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld && !sel) |=> !live_q && (op_q == OP_IDLE));

    // R8 / R10: a stalled edge changes nothing
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(op_q) && $stable(cur_addr_q) && $stable(cnt_q)
                  && $stable(wr_pend_q) && $stable(live_q));

    // R5: a pending write always belongs to a write cycle
    a_r5_pend_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend_q |-> (op_q == OP_WRITE) && (wr_addr_q == cur_addr_q));

    wire unused_hi = ^cur_addr_q[HI_W+1:2];
endmodule

// File: rtl/zbt_array.sv
// Module zbt_array
// Storage split into independent byte lanes, each with its own write enable,
// and an asynchronous read port for flow-through output.
// Assumes contents are undefined until written.
module zbt_array
    import zbt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  lane_en,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Lane write: only when the pipeline fires and this lane is enabled.
        always_ff @(posedge clk) begin
            if (we && lane_en[l]) begin
                lane_mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/zbt_sram.sv
// Module zbt_sram
// Zero-turnaround burst SRAM: composite select, delayed write data,
// flow-through reads, clock-enable stall and snooze freeze.
// Assumes AW >= 3; oe_n acts asynchronously on the output flag.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              rw_n,
    input  logic              adv_ld,
    input  logic              cke_n,
    input  logic              bwa_n,
    input  logic              bwb_n,
    input  logic              oe_n,
    input  logic              snooze,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    logic          step;
    logic          sel;
    op_e           op_q;
    logic [AW-1:0] cur_addr;
    logic          wr_pend;
    logic [AW-1:0] wr_addr;
    logic          we;

    // Edge qualification and composite chip select.
    always_comb begin
        step = !cke_n && !snooze;
        sel  = !sel_a_n && !sel_b_n && sel_c;
        we   = step && wr_pend;
    end

    zbt_ctrl #(.AW(AW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .sel        (sel),
        .rw_n       (rw_n),
        .adv_ld     (adv_ld),
        .addr       (addr),
        .op_q       (op_q),
        .cur_addr_q (cur_addr),
        .wr_pend_q  (wr_pend),
        .wr_addr_q  (wr_addr)
    );

    zbt_array #(.AW(AW)) array_i (
        .clk     (clk),
        .we      (we),
        .lane_en ({!bwb_n, !bwa_n}),
        .waddr   (wr_addr),
        .wdata   (din),
        .raddr   (cur_addr),
        .rdata   (dout)
    );

    // Output drive: only on read cycles, with oe_n low and not snoozing.
    always_comb begin
        dout_en = (op_q == OP_READ) && !oe_n && !snooze;
    end

    // R9: output is off in the cycle after a reset edge
    a_r9_off_after_reset: assert property (@(posedge clk)
        !rst_n |=> !dout_en);

    // R10: never drive while snoozing
    a_r10_snooze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> !dout_en);

    // R9: a write command never drives the bus on the next cycle
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld && sel && !rw_n) |=> !dout_en);
endmodule

// File: tb/zbt_sram_tb_top.sv
// Bench zbt_sram_tb_top
// Near-exhaustive sweep of a 256-word instance against a reference model
// built from the requirements; every cycle's output is compared.
module zbt_sram_tb_top;
    localparam int AW = 8;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          sel_a_n, sel_b_n, sel_c;
    logic          rw_n, adv_ld, cke_n, bwa_n, bwb_n, oe_n, snooze;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [DW-1:0] emem [DEPTH];
    bit            m_live, m_wr, m_pv;
    int            m_op;        // 0 idle, 1 read, 2 write
    logic [1:0]    m_start, m_cnt;
    logic [AW-1:0] m_cur, m_pa;

    always #10 clk = ~clk;  // 50 MHz

    zbt_sram #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .rw_n(rw_n), .adv_ld(adv_ld), .cke_n(cke_n),
        .bwa_n(bwa_n), .bwb_n(bwb_n), .oe_n(oe_n), .snooze(snooze),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'(a * 499 + s * 689 + 341);
    endfunction

    // One clock: drive at negedge, update model after posedge, compare.
    task automatic cyc(input bit adv, input bit [2:0] ce, input bit rw,
                       input int a, input bit [1:0] bw_n, input logic [DW-1:0] d,
                       input bit oe, input bit cke, input bit snz, input string req);
        bit exp_en;
        @(negedge clk);
        adv_ld = adv; {sel_a_n, sel_b_n, sel_c} = ce; rw_n = rw;
        addr = AW'(a); {bwb_n, bwa_n} = bw_n; din = d;
        oe_n = oe; cke_n = cke; snooze = snz;
        @(posedge clk);
        #2;
        if (!cke && !snz) begin
            if (m_pv) begin
                if (!bw_n[0]) emem[m_pa][8:0]  = d[8:0];
                if (!bw_n[1]) emem[m_pa][17:9] = d[17:9];
            end
            m_pv = 1'b0;
            if (!adv) begin
                if (ce == 3'b001) begin
                    m_live = 1; m_wr = !rw; m_start = a[1:0]; m_cnt = 0;
                    m_cur = AW'(a); m_op = rw ? 1 : 2; m_pv = !rw; m_pa = AW'(a);
                end else begin
                    m_live = 0; m_op = 0;
                end
            end else if (m_live) begin
                m_cnt = m_cnt + 2'd1;
                m_cur = {m_cur[AW-1:2], 2'(m_start + m_cnt)};
                m_op = m_wr ? 2 : 1; m_pv = m_wr; m_pa = m_cur;
            end else begin
                m_op = 0;
            end
        end
        exp_en = (m_op == 1) && !oe && !snz;
        n_chk++;
        if (dout_en !== exp_en) begin
            n_bad++;
            $display("FAIL %s: dout_en=%0b expected %0b (addr %0d)", req, dout_en, exp_en, m_cur);
        end else if (exp_en && dout !== emem[m_cur]) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected %h (addr %0d)", req, dout, emem[m_cur], m_cur);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_live = 0; m_wr = 0; m_pv = 0; m_op = 0; m_start = 0; m_cnt = 0; m_cur = 0; m_pa = 0;
        rst_n = 1'b0; addr = '0; {sel_a_n, sel_b_n, sel_c} = 3'b110;
        rw_n = 1; adv_ld = 0; cke_n = 0; bwa_n = 1; bwb_n = 1; oe_n = 0; snooze = 0; din = '0;
        repeat (3) @(posedge clk);
        #2;
        // R9: output off after reset even with oe_n low
        n_chk++;
        if (dout_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R9: dout_en=%0b after reset expected 0", dout_en);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R5 R9 R3: fill memory with write bursts; continue cycles carry rw_n=1
        for (int k = 0; k < DEPTH; k++) begin
            cyc((k % 4) != 0, 3'b001, (k % 4) != 0, k, 2'b00, pat(k - 1, 0), 0, 0, 0, "R5");
        end
        cyc(0, 3'b111, 1, 0, 2'b00, pat(DEPTH - 1, 0), 0, 0, 0, "R1");

        // R2 R4: read bursts from every start offset, wrapping on the fourth continue
        for (int b = 0; b < DEPTH / 4; b++) begin
            for (int j = 0; j < 5; j++) begin
                cyc(j != 0, 3'b001, 1, b * 4 + (b % 4), 2'b11, '0, 0, 0, 0, "R4");
            end
        end

        // R11 R5 R6: write then immediate read of the same address, all lane masks
        for (int i = 0; i < 64; i++) begin
            int a = (i * 5) % DEPTH;
            cyc(0, 3'b001, 0, a, 2'b11, '0, 0, 0, 0, "R11");
            cyc(0, 3'b001, 1, a, 2'(i % 4), pat(a, i + 7), 0, 0, 0,
                ((i % 4) == 3) ? "R6" : "R11");
        end

        // R6: abort write burst still advances: abort 4 then read the burst back
        cyc(0, 3'b001, 0, 40, 2'b11, '0, 0, 0, 0, "R6");
        for (int j = 1; j < 4; j++) cyc(1, 3'b001, 0, 0, 2'b11, pat(j, 9), 0, 0, 0, "R6");
        cyc(0, 3'b001, 1, 41, 2'b11, pat(0, 9), 0, 0, 0, "R6");
        cyc(1, 3'b110, 0, 0, 2'b11, '0, 0, 0, 0, "R6");

        // R1 R3: every unselected combination, on read and on write begins
        for (int c = 0; c < 8; c++) begin
            if (c != 1) begin
                cyc(0, 3'(c), 0, 3, 2'b11, '0, 0, 0, 0, "R1");
                cyc(1, 3'b001, 0, 3, 2'b00, pat(c, 3), 0, 0, 0, "R3");
                cyc(0, 3'b001, 1, 3, 2'b11, '0, 0, 0, 0, "R1");
                cyc(0, 3'(c), 1, 5, 2'b11, '0, 0, 0, 0, "R1");
                cyc(1, 3'(c), 1, 5, 2'b11, '0, 0, 0, 0, "R3");
            end
        end

        // R7: dummy read begin, visible continue advances
        cyc(0, 3'b001, 1, 100, 2'b11, '0, 1, 0, 0, "R7");
        cyc(1, 3'b001, 1, 0, 2'b11, '0, 0, 0, 0, "R7");
        cyc(1, 3'b001, 1, 0, 2'b11, '0, 1, 0, 0, "R7");
        cyc(1, 3'b001, 1, 0, 2'b11, '0, 0, 0, 0, "R7");

        // R8: stalled edges hold read data, then pending write waits for next enabled edge
        cyc(0, 3'b001, 1, 60, 2'b11, '0, 0, 0, 0, "R8");
        cyc(0, 3'b110, 0, 7, 2'b00, '1, 0, 1, 0, "R8");
        cyc(1, 3'b001, 0, 9, 2'b00, '1, 0, 1, 0, "R8");
        cyc(0, 3'b001, 0, 61, 2'b11, '0, 0, 0, 0, "R9");
        cyc(0, 3'b001, 1, 0, 2'b00, '1, 0, 1, 0, "R8");
        cyc(0, 3'b001, 1, 61, 2'b01, pat(61, 1), 0, 0, 0, "R8");

        // R10: snooze in mid-burst with garbage inputs, then resume
        cyc(0, 3'b001, 1, 130, 2'b11, '0, 0, 0, 0, "R10");
        cyc(1, 3'b001, 1, 0, 2'b11, '0, 0, 0, 0, "R10");
        cyc(0, 3'b001, 0, 7, 2'b00, '1, 0, 0, 1, "R10");
        cyc(0, 3'b110, 0, 9, 2'b00, '1, 0, 1, 1, "R10");
        cyc(1, 3'b001, 1, 0, 2'b11, '0, 0, 0, 0, "R10");
        cyc(1, 3'b001, 1, 0, 2'b11, '0, 0, 0, 0, "R10");
        cyc(0, 3'b001, 1, 7, 2'b11, '0, 0, 0, 0, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule